// File: doc/BRIEF.md
# Look-Ahead Registered Count Decoder

This block is a synchronous binary up-counter whose "count has reached the target" indication comes directly from a flip-flop. The flag is never decoded from the counter bits after the clock edge. In each cycle, the control logic works out what the count will be after the coming edge. It uses the current count, the enable and the clear. It then loads the flag register with the result of comparing that predicted value against the target.

Because the predicted value is compared before the edge, the flag flop changes on the same edge as the counter. The output therefore carries only clock-to-Q delay. It also cannot show the hazard pulses that a sum-of-products decode of several changing counter bits can produce.

The block suits any place where a count-based strobe must be clean, for example when it leaves the chip or feeds an asynchronous consumer. The counter width and the target value are parameters. Synchronous reset and synchronous clear both return the counter to zero.

Top module: `lookahead_decoder`

## Requirements
- R1: In every cycle outside reset, `hit` is 1 exactly when `count` equals the target (parameter `TARGET`, default 4, taken modulo 2^`CNT_W`), and 0 otherwise.
- R2: `hit` rises only on an edge where, in the cycle before, `en` was 1, `clr` was 0 and `count` was one below the target, modulo 2^`CNT_W`.
- R3: When `count` equals the target and the counter advances, `hit` is 0 in the very next cycle, together with the new count.
- R4: While `en` is 0 and `clr` is 0, `count` and `hit` both hold their values. A flag that is high at the target stays high for the whole stall.
- R5: `clr` = 1 forces `count` to 0 on the next edge, and `hit` to 1 if the target is 0, otherwise to 0. `clr` takes priority over `en`.
- R6: `rst` = 1 has the same synchronous effect as `clr`, so after reset `count` is 0 and `hit` equals (target == 0).
- R7: With `en` = 1 and `clr` = 0, `count` increases by one per cycle. It wraps from 2^`CNT_W`−1 to 0.
- R8: A target of 0 is reached by wrap-around: `hit` goes high on the edge where the count wraps from its maximum value to 0.
- R9: `hit` is driven directly by a register. There is no logic between the register and the port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable |
| clr | input | 1 | Synchronous clear to zero, active high, overrides `en` |
| count | output | CNT_W | Current counter value |
| hit | output | 1 | Registered flag, high while `count` equals the target |

## Verification
The decoder is driven with four kinds of input: long unbroken enable runs, stalls parked exactly one below the target and exactly at the target, clears placed on and around the target, and a long random mix of enable and clear.

- The unbroken runs show that the prediction rises and falls on the right edges, including the wrap back to zero.
- The stall one below the target separates a flag that correctly checks the enable from one that predicts from the count alone.
- The stall at the target exposes a flag that drops early or holds a stale value.
- A second instance with a narrow counter and a target of 0 checks the clear-to-high reset value and the target reached by wrap-around.

// File: rtl/lookahead_pkg.sv
package lookahead_pkg;

  // Strobes from control to datapath, one per counter action.
  typedef struct packed {
    logic clearNow;  // load zero on the next edge (reset or clear)
    logic advance;   // increment on the next edge
  } ctrlStrobes_t;

endpackage

// File: rtl/count_datapath.sv
module count_datapath
  import lookahead_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  ctrlStrobes_t     strobes,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] countPlusOne
);

  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  // Natural modulo-2^CNT_W wrap from the truncated add.
  always_comb countPlusOne = count + ONE;

  always_ff @(posedge clk) begin
    if (strobes.clearNow) begin
      count <= ZERO;
    end else if (strobes.advance) begin
      count <= countPlusOne;
    end
  end

endmodule

// File: rtl/lookahead_ctrl.sv
module lookahead_ctrl
  import lookahead_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int TARGET = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic [CNT_W-1:0] countPlusOne,
  output ctrlStrobes_t     strobes,
  output logic             flagQ
);

  localparam logic [CNT_W-1:0] TGT = CNT_W'(TARGET);
  // Flag value that matches a count of zero.
  localparam logic ZERO_FLAG = (TGT == '0);

  logic predictHit;
  logic flagNext;

  always_comb begin
    strobes.clearNow = rst | clr;
    strobes.advance  = en & ~(rst | clr);
  end

  // Compare the value the count will take, not the value it holds.
  always_comb predictHit = (countPlusOne == TGT);

  always_comb begin
    if (strobes.clearNow) begin
      flagNext = ZERO_FLAG;
    end else if (strobes.advance) begin
      flagNext = predictHit;
    end else begin
      flagNext = flagQ;
    end
  end

  always_ff @(posedge clk) flagQ <= flagNext;

endmodule

// File: rtl/lookahead_decoder.sv
module lookahead_decoder
  import lookahead_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int TARGET = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             clr,
  output logic [CNT_W-1:0] count,
  output logic             hit
);

  ctrlStrobes_t     strobes;
  logic [CNT_W-1:0] countPlusOne;
  logic             flagQ;

  lookahead_ctrl #(.CNT_W(CNT_W), .TARGET(TARGET)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .clr          (clr),
    .en           (en),
    .countPlusOne (countPlusOne),
    .strobes      (strobes),
    .flagQ        (flagQ)
  );

  count_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk          (clk),
    .strobes      (strobes),
    .count        (count),
    .countPlusOne (countPlusOne)
  );

  // Straight wire from the flag register (R9).
  assign hit = flagQ;

endmodule

// File: rtl/lookahead_decoder_chk.sv
module lookahead_decoder_chk #(
  parameter int CNT_W  = 4,
  parameter int TARGET = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             clr,
  input logic [CNT_W-1:0] count,
  input logic             hit
);

  localparam logic [CNT_W-1:0] TGT    = CNT_W'(TARGET);
  localparam logic [CNT_W-1:0] PRE    = TGT + {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);
  localparam logic [CNT_W-1:0] MAXV   = {CNT_W{1'b1}};
  localparam logic             ZFLAG  = (TGT == '0);

  // R1
  flag_match_chk: assert property (@(posedge clk) disable iff (rst)
    hit == (count == TGT));

  // R2
  flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(hit) && !$past(rst) && !$past(clr)) |-> ($past(en) && $past(count) == PRE));

  // R3
  flag_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !clr && count == TGT) |=> !hit);

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> ($stable(count) && $stable(hit)));

  // R5
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count == '0 && hit == ZFLAG));

  // R7
  step_one_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !clr) |=> (count == $past(count) + ONE));

  // R8
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !clr && count == MAXV) |=> (count == '0 && hit == ZFLAG));

endmodule

bind lookahead_decoder lookahead_decoder_chk #(.CNT_W(CNT_W), .TARGET(TARGET)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .en    (en),
  .clr   (clr),
  .count (count),
  .hit   (hit)
);

// File: tb/lookahead_decoder_bench.sv
`timescale 1ns/1ps
module lookahead_decoder_bench;

  localparam int WA = 4, TA = 4;   // default instance
  localparam int WB = 3, TB = 0;   // target reached by wrap-around

  typedef struct {
    logic [WA-1:0] cA;
    logic          fA;
    logic [WB-1:0] cB;
    logic          fB;
  } expItem_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic clr = 1'b0;
  logic [WA-1:0] countA;
  logic          hitA;
  logic [WB-1:0] countB;
  logic          hitB;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  expItem_t expQ[$];
  string    tagQ[$];

  logic [WA-1:0] mA = '0;
  logic [WB-1:0] mB = '0;

  always #4 clk = ~clk;  // 125 MHz

  lookahead_decoder #(.CNT_W(WA), .TARGET(TA)) u_lookahead_decoder (
    .clk(clk), .rst(rst), .en(en), .clr(clr), .count(countA), .hit(hitA));

  lookahead_decoder #(.CNT_W(WB), .TARGET(TB)) u_lookahead_decoder_wrap (
    .clk(clk), .rst(rst), .en(en), .clr(clr), .count(countB), .hit(hitB));

  // Driver: applies inputs and pushes what the next edge must produce.
  task automatic drive(input logic r, input logic e, input logic c);
    expItem_t it;
    string tag;
    @(negedge clk);
    rst = r; en = e; clr = c;
    if (r) tag = "R6 reset";
    else if (c) tag = "R5 clear";
    else if (!e) tag = (mA == TA) ? "R4 stall at target" : "R4 stall";
    else if (mA == TA) tag = "R3 leave target";
    else if (mA == TA - 1) tag = "R2 arrive target";
    else if (mB == '1) tag = "R8 wrap to target 0";
    else tag = "R7 increment";
    if (r || c) begin
      mA = '0; mB = '0;
    end else if (e) begin
      mA = mA + 1'b1; mB = mB + 1'b1;
    end
    it.cA = mA; it.fA = (mA == WA'(TA));
    it.cB = mB; it.fB = (mB == WB'(TB));
    expQ.push_back(it);
    tagQ.push_back(tag);
  endtask

  // Monitor: compares mid-cycle after each edge (R1 reference every cycle).
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() != 0) begin
        expItem_t it;
        string tag;
        it  = expQ.pop_front();
        tag = tagQ.pop_front();
        checks += 2;
        if (countA !== it.cA || hitA !== it.fA) begin
          failures++;
          $display("FAIL %s (R1 inst A): count=%0d hit=%0b expected count=%0d hit=%0b",
                   tag, countA, hitA, it.cA, it.fA);
        end
        if (countB !== it.cB || hitB !== it.fB) begin
          failures++;
          $display("FAIL %s (R1 inst B): count=%0d hit=%0b expected count=%0d hit=%0b",
                   tag, countB, hitB, it.cB, it.fB);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R6: reset state
    drive(1, 0, 0);
    drive(1, 1, 0);
    // R7 / R8 / R2 / R3: unbroken run through target and both wraps
    for (int i = 0; i < 20; i++) drive(0, 1, 0);
    // R2 stall one below target
    drive(0, 0, 1);
    for (int i = 0; i < 3; i++) drive(0, 1, 0);
    for (int i = 0; i < 4; i++) drive(0, 0, 0);
    drive(0, 1, 0);
    // R4 stall at target
    for (int i = 0; i < 5; i++) drive(0, 0, 0);
    // R5 clear beats enable, while at target
    drive(0, 1, 1);
    drive(0, 0, 0);
    // R6 reset mid-count
    for (int i = 0; i < 6; i++) drive(0, 1, 0);
    drive(1, 1, 0);
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic e, c;
      e = ($urandom_range(0, 3) != 0);
      c = ($urandom_range(0, 15) == 0);
      drive(0, e, c);
    end
    drive(0, 0, 0);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule